// File: doc/BRIEF.md
# Priority Process State Issuer

The block runs a configurable number of simultaneous processes. On every clock cycle each process picks one current state from its ordered list of states, and there is no shared instruction pointer. Each state has a condition bit. The highest state whose condition is true wins. The lowest state (index 0) is the default, most probable state: a process falls into it when no higher condition is set. The condition bits carry whatever stimulates the process, such as queue-not-empty flags, feedback-valid flags and loop register tests.

Each instructed resource belongs to exactly one process, so two processes can never contend for a resource. A resource holds a local instruction memory addressed by a task select together with its owner's current state. From that memory it produces a registered instruction word and a registered use bit, which is meant to gate the resource's clock. Ownership and instruction memories are loaded through simple write ports, and a write is honoured only while every process is disabled.

Top module: `proc_state_issuer`

## Requirements
- R1: While reset is asserted, every issued state, every instruction word and every use bit is 0. Resource r starts owned by process r mod NUM_PROC.
- R2: For an enabled process p, the state issued after a clock edge is the highest index s (1..NUM_STATE-1) with cond_i[p*NUM_STATE+s] set at that edge, or 0 if none is set. Bit 0 of each process's conditions has no effect.
- R3: Every process updates its state on every clock edge, independently of the other processes' conditions and enables.
- R4: A process whose proc_en_i bit is 0 at an edge issues state 0 after that edge, whatever its conditions.
- R5: One edge after a state is issued, the instruction word of resource r (instr_o[r*INSTR_W +: INSTR_W]) equals resource r's memory word at address {task_i, owner's state}, with task_i sampled at that same edge.
- R6: One edge after a state is issued, use_o[r] equals the enable bit its owning process had when that state was issued.
- R7: A write to a local instruction memory (imem_we_i, with resource imem_res_i, address imem_addr_i = {task, state}) is stored only if all proc_en_i bits are 0 at that edge. Otherwise it is ignored.
- R8: An ownership write (own_we_i) sets resource own_res_i to process own_proc_i. It is ignored if any proc_en_i bit is 1 or if own_proc_i >= NUM_PROC.
- R9: The task select forms the upper address bits, so distinct task_i values with the same state read distinct memory words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| proc_en_i | input | NUM_PROC | Per-process enable |
| cond_i | input | NUM_PROC*NUM_STATE | Per-process, per-state condition bits |
| task_i | input | TASK_W | Task select, upper instruction address bits |
| own_we_i | input | 1 | Ownership write strobe |
| own_res_i | input | $clog2(NUM_RES) | Resource being reassigned |
| own_proc_i | input | $clog2(NUM_PROC) | New owning process |
| imem_we_i | input | 1 | Instruction memory write strobe |
| imem_res_i | input | $clog2(NUM_RES) | Target resource |
| imem_addr_i | input | TASK_W+$clog2(NUM_STATE) | Write address {task, state} |
| imem_data_i | input | INSTR_W | Write data |
| state_o | output | NUM_PROC*$clog2(NUM_STATE) | Issued state per process |
| instr_o | output | NUM_RES*INSTR_W | Registered local instruction per resource |
| use_o | output | NUM_RES | Registered use bit per resource |

## Verification
The states are driven with random condition words that mix dense and sparse bit patterns. Dense words show whether the highest set bit wins. Sparse and all-zero words show the fall to the default state and that condition bit 0 is ignored. Random task selects combined with a reshuffled ownership map show whether each resource reads with its own owner's state and the correct upper address bits. Random enable masks separate the per-process hold-low behaviour from the use-bit gating. Writes attempted while processes run, and ownership codes beyond the process count, show that illegal configuration writes leave the outputs untouched.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int DEF_NUM_PROC  = 4;
  localparam int DEF_NUM_STATE = 8;
  localparam int DEF_NUM_RES   = 8;
  localparam int DEF_TASK_W    = 5;
  localparam int DEF_INSTR_W   = 16;
endpackage

// File: rtl/pss_prio_sel.sv
module pss_prio_sel #(
  parameter int NUM_STATE = 8,
  localparam int SW = $clog2(NUM_STATE)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [NUM_STATE-1:0] cond_i,
  output logic [SW-1:0]        state_o
);
  logic [SW-1:0] nxt;

  // ascending scan: the last (highest) set bit wins; bit 0 is the default
  always_comb begin
    nxt = '0;
    for (int s = 1; s < NUM_STATE; s++) begin
      if (cond_i[s]) nxt = SW'(s);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_o <= '0;
    else if (en_i)  state_o <= nxt;
    else            state_o <= '0;
  end
endmodule

// File: rtl/pss_res_slot.sv
module pss_res_slot #(
  parameter int NUM_PROC  = 4,
  parameter int NUM_STATE = 8,
  parameter int TASK_W    = 5,
  parameter int INSTR_W   = 16,
  parameter int RES_IDX   = 0,
  localparam int SW    = $clog2(NUM_STATE),
  localparam int PW    = $clog2(NUM_PROC),
  localparam int AW    = TASK_W + SW,
  localparam int DEPTH = 1 << AW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_PROC*SW-1:0] state_i,
  input  logic [NUM_PROC-1:0]    en_i,
  input  logic [TASK_W-1:0]      task_i,
  input  logic                   own_wr_i,
  input  logic [PW-1:0]          own_proc_i,
  input  logic                   mem_wr_i,
  input  logic [AW-1:0]          mem_addr_i,
  input  logic [INSTR_W-1:0]     mem_data_i,
  output logic [PW-1:0]          owner_o,
  output logic [INSTR_W-1:0]     instr_o,
  output logic                   use_o
);
  logic [INSTR_W-1:0] mem [DEPTH];
  logic [SW-1:0]      own_state;
  logic               own_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       owner_o <= PW'(RES_IDX % NUM_PROC);
    else if (own_wr_i) owner_o <= own_proc_i;
  end

  always_ff @(posedge clk_i) begin
    if (mem_wr_i) mem[mem_addr_i] <= mem_data_i;
  end

  always_comb begin
    own_state = state_i[owner_o*SW +: SW];
    own_en    = en_i[owner_o];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_o <= '0;
      use_o   <= 1'b0;
    end else begin
      instr_o <= mem[{task_i, own_state}];
      use_o   <= own_en;
    end
  end
endmodule

// File: rtl/proc_state_issuer.sv
module proc_state_issuer
  import pss_pkg::*;
#(
  parameter int NUM_PROC  = DEF_NUM_PROC,
  parameter int NUM_STATE = DEF_NUM_STATE,
  parameter int NUM_RES   = DEF_NUM_RES,
  parameter int TASK_W    = DEF_TASK_W,
  parameter int INSTR_W   = DEF_INSTR_W,
  localparam int SW = $clog2(NUM_STATE),
  localparam int PW = $clog2(NUM_PROC),
  localparam int RW = $clog2(NUM_RES),
  localparam int AW = TASK_W + SW
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PROC-1:0]           proc_en_i,
  input  logic [NUM_PROC*NUM_STATE-1:0] cond_i,
  input  logic [TASK_W-1:0]             task_i,
  input  logic                          own_we_i,
  input  logic [RW-1:0]                 own_res_i,
  input  logic [PW-1:0]                 own_proc_i,
  input  logic                          imem_we_i,
  input  logic [RW-1:0]                 imem_res_i,
  input  logic [AW-1:0]                 imem_addr_i,
  input  logic [INSTR_W-1:0]            imem_data_i,
  output logic [NUM_PROC*SW-1:0]        state_o,
  output logic [NUM_RES*INSTR_W-1:0]    instr_o,
  output logic [NUM_RES-1:0]            use_o
);
  logic                  all_idle;
  logic                  own_ok;
  logic [NUM_PROC-1:0]   en_q;
  logic [NUM_RES*PW-1:0] owner_flat;

  assign all_idle = ~|proc_en_i;
  assign own_ok   = own_we_i && all_idle && (int'(own_proc_i) < NUM_PROC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= proc_en_i;
  end

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
    pss_prio_sel #(.NUM_STATE(NUM_STATE)) u_sel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (proc_en_i[p]),
      .cond_i  (cond_i[p*NUM_STATE +: NUM_STATE]),
      .state_o (state_o[p*SW +: SW])
    );
  end

  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    logic own_wr, mem_wr;
    assign own_wr = own_ok && (int'(own_res_i) == r);
    assign mem_wr = imem_we_i && all_idle && (int'(imem_res_i) == r);

    pss_res_slot #(
      .NUM_PROC (NUM_PROC),
      .NUM_STATE(NUM_STATE),
      .TASK_W   (TASK_W),
      .INSTR_W  (INSTR_W),
      .RES_IDX  (r)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .state_i    (state_o),
      .en_i       (en_q),
      .task_i     (task_i),
      .own_wr_i   (own_wr),
      .own_proc_i (own_proc_i),
      .mem_wr_i   (mem_wr),
      .mem_addr_i (imem_addr_i),
      .mem_data_i (imem_data_i),
      .owner_o    (owner_flat[r*PW +: PW]),
      .instr_o    (instr_o[r*INSTR_W +: INSTR_W]),
      .use_o      (use_o[r])
    );
  end
endmodule

// File: rtl/pss_chk.sv
module pss_chk #(
  parameter int NUM_PROC  = 4,
  parameter int NUM_STATE = 8,
  parameter int NUM_RES   = 8,
  localparam int SW = $clog2(NUM_STATE),
  localparam int PW = $clog2(NUM_PROC)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_PROC-1:0]           proc_en_i,
  input logic [NUM_PROC*NUM_STATE-1:0] cond_i,
  input logic                          own_we_i,
  input logic [NUM_PROC*SW-1:0]        state_o,
  input logic [NUM_RES-1:0]            use_o,
  input logic [NUM_RES*PW-1:0]         owner_flat
);
  for (genvar p = 0; p < NUM_PROC; p++) begin : g_p
    p_prio_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      proc_en_i[p] && cond_i[p*NUM_STATE + NUM_STATE-1]
      |=> state_o[p*SW +: SW] == SW'(NUM_STATE-1));

    p_default_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      proc_en_i[p] && (cond_i[p*NUM_STATE+1 +: NUM_STATE-1] == '0)
      |=> state_o[p*SW +: SW] == '0);

    p_disabled_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !proc_en_i[p] |=> state_o[p*SW +: SW] == '0);
  end

  p_own_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_we_i && (|proc_en_i) |=> $stable(owner_flat));

  p_use_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|use_o) |-> $past(|proc_en_i, 2));
endmodule

bind proc_state_issuer pss_chk #(
  .NUM_PROC (NUM_PROC),
  .NUM_STATE(NUM_STATE),
  .NUM_RES  (NUM_RES)
) u_pss_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .proc_en_i  (proc_en_i),
  .cond_i     (cond_i),
  .own_we_i   (own_we_i),
  .state_o    (state_o),
  .use_o      (use_o),
  .owner_flat (owner_flat)
);

// File: tb/proc_state_issuer_tb_top.sv
`timescale 1ns/1ps
module proc_state_issuer_tb_top;
  localparam int K  = 6;
  localparam int S  = 8;
  localparam int R  = 8;
  localparam int TW = 5;
  localparam int IW = 16;
  localparam int SW = 3;
  localparam int PW = 3;
  localparam int RW = 3;
  localparam int AW = TW + SW;
  localparam int D  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [K-1:0]    proc_en = '0;
  logic [K*S-1:0]  cond = '0;
  logic [TW-1:0]   tsk = '0;
  logic            own_we = 1'b0;
  logic [RW-1:0]   own_res = '0;
  logic [PW-1:0]   own_proc = '0;
  logic            imem_we = 1'b0;
  logic [RW-1:0]   imem_res = '0;
  logic [AW-1:0]   imem_addr = '0;
  logic [IW-1:0]   imem_data = '0;
  logic [K*SW-1:0] state_o;
  logic [R*IW-1:0] instr_o;
  logic [R-1:0]    use_o;

  proc_state_issuer #(.NUM_PROC(K), .NUM_STATE(S), .NUM_RES(R), .TASK_W(TW), .INSTR_W(IW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .proc_en_i(proc_en), .cond_i(cond), .task_i(tsk),
    .own_we_i(own_we), .own_res_i(own_res), .own_proc_i(own_proc),
    .imem_we_i(imem_we), .imem_res_i(imem_res), .imem_addr_i(imem_addr), .imem_data_i(imem_data),
    .state_o(state_o), .instr_o(instr_o), .use_o(use_o));

  // behavioural reference
  logic [IW-1:0] m_mem [R][D];
  int   m_st [K];
  bit   m_en [K];
  int   m_own [R];
  logic [IW-1:0] m_instr [R];
  bit   m_use [R];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   chk_instr = 1'b0;
  string phase = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < K; p++) begin m_st[p] = 0; m_en[p] = 0; end
      for (int r = 0; r < R; r++) begin m_own[r] = r % K; m_instr[r] = '0; m_use[r] = 0; end
    end else begin
      bit idle;
      idle = (proc_en == '0);
      for (int r = 0; r < R; r++) begin
        m_instr[r] = m_mem[r][int'(tsk) * S + m_st[m_own[r]]];
        m_use[r]   = m_en[m_own[r]];
      end
      for (int p = 0; p < K; p++) begin
        int w;
        w = 0;
        for (int s = S-1; s >= 1; s--) if (w == 0 && cond[p*S+s]) w = s;
        m_en[p] = proc_en[p];
        m_st[p] = proc_en[p] ? w : 0;
      end
      if (imem_we && idle) m_mem[imem_res][imem_addr] = imem_data;
      if (own_we && idle && int'(own_proc) < K) m_own[own_res] = int'(own_proc);
    end
  end

  task automatic check(string req, string what, int a, int e);
    n_chk++;
    if (a != e) begin
      n_fail++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d at cycle %0d", req, phase, what, a, e, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < K; p++)
        check("R2", $sformatf("state p%0d", p), int'(state_o[p*SW +: SW]), m_st[p]);
      for (int r = 0; r < R; r++) begin
        check("R6", $sformatf("use r%0d", r), int'(use_o[r]), int'(m_use[r]));
        if (chk_instr)
          check("R5", $sformatf("instr r%0d", r), int'(instr_o[r*IW +: IW]), int'(m_instr[r]));
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
      summary();
    end
  end

  task automatic rnd_run(int n, bit rnd_en);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cond    = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) cond = cond & {2{$urandom & 32'h0101_0101}};
      proc_en = rnd_en ? K'($urandom) : '1;
      tsk     = TW'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "state during reset", int'(state_o), 0);
    check("R1", "instr during reset", int'(instr_o[31:0]), 0);
    check("R1", "use during reset", int'(use_o), 0);
    rst_n = 1'b1;

    // R8 legal reassignment and an out-of-range owner code
    phase = "R8";
    for (int r = 0; r < R; r++) begin
      @(negedge clk);
      own_we = 1'b1; own_res = RW'(r); own_proc = PW'((r * 5 + 1) % K);
    end
    @(negedge clk); own_res = 3'd2; own_proc = 3'd7;
    @(negedge clk); own_res = 3'd4; own_proc = 3'd6;
    @(negedge clk); own_we = 1'b0;

    // R7 load every memory word while idle
    phase = "R7";
    for (int r = 0; r < R; r++)
      for (int a = 0; a < D; a++) begin
        @(negedge clk);
        imem_we = 1'b1; imem_res = RW'(r); imem_addr = AW'(a);
        imem_data = IW'((r * 4099 + a * 131 + 7) ^ (a << 3));
      end
    @(negedge clk); imem_we = 1'b0;
    repeat (2) @(negedge clk);
    chk_instr = 1'b1;

    // R2, R3, R5, R9 all processes running, random conditions and tasks
    phase = "R9";
    rnd_run(3000, 1'b0);

    // R4, R6 random enable masks
    phase = "R4";
    rnd_run(3000, 1'b1);

    // R7 writes attempted while processes run must be dropped
    phase = "R7";
    for (int r = 0; r < R; r++) begin
      @(negedge clk);
      proc_en = K'(1 << (r % K)); cond = '1; tsk = 5'd3;
      imem_we = 1'b1; imem_res = RW'(r); imem_addr = {5'd3, 3'd7}; imem_data = 16'hDEAD;
    end
    @(negedge clk); imem_we = 1'b0; proc_en = '1; cond = '1; tsk = 5'd3;
    repeat (3) @(negedge clk);
    for (int r = 0; r < R; r++)
      check("R7", $sformatf("word kept r%0d", r), int'(instr_o[r*IW +: IW]),
            int'(IW'((r * 4099 + (3 * 8 + 7) * 131 + 7) ^ ((3 * 8 + 7) << 3))));

    // R8 ownership writes while running must be dropped, then reassign while idle
    phase = "R8";
    for (int r = 0; r < R; r++) begin
      @(negedge clk);
      own_we = 1'b1; own_res = RW'(r); own_proc = 3'd0;
    end
    @(negedge clk); own_we = 1'b0;
    rnd_run(500, 1'b0);
    @(negedge clk); proc_en = '0;
    for (int r = 0; r < R; r++) begin
      @(negedge clk);
      own_we = 1'b1; own_res = RW'(r); own_proc = PW'((R - r) % K);
    end
    @(negedge clk); own_we = 1'b0;
    phase = "R3";
    rnd_run(2000, 1'b1);
    rnd_run(1000, 1'b0);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule